// File: doc/BRIEF.md
# Data Port Byte Buffer

This block sits between a 16-bit CPU data register and a small byte buffer that a transfer sequencer fills (receive) or drains (transmit). A CPU write of 16 bits deposits two bytes, and an 8-bit write deposits a single byte, which software uses for the odd final byte of a transmit. A CPU read returns up to two received bytes in one 16-bit word. A run-time byte-order input selects which half of the 16-bit word pairs with which buffer position. The same rule applies to reads and to writes.

Every CPU access drives one-cycle status set and clear pulses toward a status register kept elsewhere. The bit positions of these pulses are fixed because that register decodes them. Each access also sends a one-cycle request that tells the sequencer to carry on. A read made while the controller is master and receiving also signals access-ready and asks for the master bit to be dropped. The buffer fill level is always visible. On the sequencer side, transmit takes bytes from the highest filled position downward and receive appends bytes upward from position 0.

Top module: `dport_bytebuf`

## Requirements
- R1: After reset, fill is 0, rd_data is 0, and stat_set, stat_clr, mst_clr and run_req are all low.
- R2: With hi_first=1, a 16-bit write moves the held bytes up by two positions, places wr_data[15:8] at position 1 and wr_data[7:0] at position 0, and raises fill by 2.
- R3: With hi_first=0, the byte pairing is reversed for writes (wr_data[7:0] to position 1, wr_data[15:8] to position 0) and for reads (position 0 in rd_data[7:0], position 1 in rd_data[15:8]).
- R4: An 8-bit write (wr_byte=1) moves the held bytes up by one position, places wr_data[7:0] at position 0 and raises fill by 1.
- R5: seq_tx_byte shows the byte at the highest filled position (0 when empty). A seq_pop lowers fill by 1, and a pop on an empty buffer leaves fill at 0.
- R6: seq_push stores seq_push_byte at position fill and raises fill by 1. A push on a full buffer changes neither fill nor contents.
- R7: A read with fill of 2 or more returns position 0 in rd_data[15:8] and position 1 in rd_data[7:0] (when hi_first=1), consumes two bytes and moves the rest down by two. With fill of 1 it returns the single byte in the lane for position 0, 0 in the other lane, and empties the buffer. rd_data updates one cycle after the read and holds until the next read.
- R8: A read with an empty buffer returns 0 and pulses stat_set bit 15.
- R9: Every write pulses stat_clr bits 10 (transmit underflow) and 4 (transmit ready) in the following cycle.
- R10: Every read pulses stat_clr bits 3 (receive ready) and 11 (receive overrun) in the following cycle.
- R11: A read with mst_in=1 and rx_mode=1 pulses stat_set bit 2 (access ready) and mst_clr in the following cycle. Otherwise neither pulses.
- R12: run_req is high for exactly the one cycle after each accepted CPU access and low otherwise.
- R13: A write with too little room for all its bytes leaves fill and contents unchanged, but still produces its R9 and R12 pulses.
- R14: A CPU access takes priority. A seq_push or seq_pop in the same cycle is ignored, and a read issued together with a write is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_first | input | 1 | Byte order: 1 pairs position 0 with bits 15:8 on reads |
| mst_in | input | 1 | Controller is bus master |
| rx_mode | input | 1 | Transfer direction is receive |
| wr_en | input | 1 | CPU write strobe |
| wr_byte | input | 1 | Write is 8 bits wide |
| wr_data | input | 16 | CPU write data |
| rd_en | input | 1 | CPU read strobe |
| rd_data | output | 16 | CPU read data, registered |
| seq_push | input | 1 | Sequencer appends a received byte |
| seq_push_byte | input | 8 | Received byte |
| seq_pop | input | 1 | Sequencer takes a transmit byte |
| seq_tx_byte | output | 8 | Byte at highest filled position |
| fill | output | FILL_W (3) | Bytes held |
| stat_set | output | 16 | One-cycle status set pulses |
| stat_clr | output | 16 | One-cycle status clear pulses |
| mst_clr | output | 1 | Pulse: drop the master bit |
| run_req | output | 1 | Pulse: sequencer should continue |

## Verification
The bench builds the block with its defaults: BUF_BYTES=4 and PORT_W=16. With this small depth the full-buffer cases are reached after two 16-bit writes or four pushes. Under those conditions the bench exercises refused writes, refused pushes and the one-byte tail read alongside the normal paths. Both settings of hi_first are driven across writes and reads. A scoreboard checks the transmit order and the read words that both orders produce.

// File: rtl/dbb_pkg.sv
`timescale 1ns/1ps
package dbb_pkg;
   localparam int BYTE_W = 8;
   localparam int STAT_W = 16;

   // status bit positions decoded by the neighbouring status register
   localparam int ST_ARDY    = 2;
   localparam int ST_RXRDY   = 3;
   localparam int ST_TXRDY   = 4;
   localparam int ST_TXUDF   = 10;
   localparam int ST_RXOVR   = 11;
   localparam int ST_RDEMPTY = 15;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_WR2  = 3'd1,
      OP_WR1  = 3'd2,
      OP_RD   = 3'd3,
      OP_PUSH = 3'd4,
      OP_POP  = 3'd5
   } buf_op_e;
endpackage

// File: rtl/dbb_store.sv
`timescale 1ns/1ps
module dbb_store
   import dbb_pkg::*;
#(
   parameter  int DEPTH  = 4,
   localparam int FILL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  buf_op_e           op,
   input  byte_t             ins_lo,
   input  byte_t             ins_hi,
   input  byte_t             push_byte,
   output byte_t             head0,
   output byte_t             head1,
   output byte_t             tail,
   output logic [FILL_W-1:0] fill
);
   localparam int IDX_W = $clog2(DEPTH);

   byte_t             mem [DEPTH];
   byte_t             nxt [DEPTH];
   logic [FILL_W-1:0] fill_q, fill_d;
   logic              room1, room2, take2, nonempty;

   assign room1    = fill_q <  FILL_W'(DEPTH);
   assign room2    = fill_q <= FILL_W'(DEPTH - 2);
   assign take2    = fill_q >= FILL_W'(2);
   assign nonempty = fill_q != '0;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      byte_t up1, up2, dn1, dn2;
      if (i >= 2) begin : g_up2_mem
         assign up2 = mem[i-2];
      end else if (i == 1) begin : g_up2_hi
         assign up2 = ins_hi;
      end else begin : g_up2_lo
         assign up2 = ins_lo;
      end
      if (i >= 1) begin : g_up1_mem
         assign up1 = mem[i-1];
      end else begin : g_up1_lo
         assign up1 = ins_lo;
      end
      if (i + 1 < DEPTH) begin : g_dn1_mem
         assign dn1 = mem[i+1];
      end else begin : g_dn1_zero
         assign dn1 = '0;
      end
      if (i + 2 < DEPTH) begin : g_dn2_mem
         assign dn2 = mem[i+2];
      end else begin : g_dn2_zero
         assign dn2 = '0;
      end
      assign nxt[i] = (op == OP_WR2 && room2)                         ? up2 :
                      (op == OP_WR1 && room1)                         ? up1 :
                      (op == OP_RD && nonempty)                       ? (take2 ? dn2 : dn1) :
                      (op == OP_PUSH && room1 && fill_q == FILL_W'(i)) ? push_byte :
                                                                        mem[i];
   end

   always_comb begin
      fill_d = fill_q;
      case (op)
         OP_WR2:  if (room2) fill_d = fill_q + FILL_W'(2);
         OP_WR1:  if (room1) fill_d = fill_q + FILL_W'(1);
         OP_PUSH: if (room1) fill_d = fill_q + FILL_W'(1);
         OP_POP:  if (nonempty) fill_d = fill_q - FILL_W'(1);
         OP_RD: begin
            if (take2)         fill_d = fill_q - FILL_W'(2);
            else if (nonempty) fill_d = fill_q - FILL_W'(1);
         end
         default: fill_d = fill_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         fill_q <= fill_d;
         mem    <= nxt;
      end
   end

   assign head0 = mem[0];
   assign head1 = mem[1];
   assign tail  = nonempty ? mem[IDX_W'(fill_q - FILL_W'(1))] : '0;
   assign fill  = fill_q;

   a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= FILL_W'(DEPTH));
   a_r2_wr2_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_WR2 && fill_q <= FILL_W'(DEPTH - 2)) |=> fill_q == $past(fill_q) + FILL_W'(2));
   a_r13_full_write_held: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_WR2 && fill_q > FILL_W'(DEPTH - 2)) |=> fill_q == $past(fill_q));
   a_r5_pop_empty_held: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_POP && fill_q == '0) |=> fill_q == '0);
endmodule

// File: rtl/dbb_lane.sv
`timescale 1ns/1ps
module dbb_lane
   import dbb_pkg::*;
#(
   parameter int PORT_W = 16,
   parameter int FILL_W = 3
) (
   input  logic              hi_first,
   input  logic              byte_mode,
   input  logic [PORT_W-1:0] wr_word,
   input  byte_t             head0,
   input  byte_t             head1,
   input  logic [FILL_W-1:0] fill,
   output byte_t             ins_hi,
   output byte_t             ins_lo,
   output logic [PORT_W-1:0] rd_word
);
   byte_t w_upper, w_lower, r0, r1;

   assign w_upper = wr_word[2*BYTE_W-1:BYTE_W];
   assign w_lower = wr_word[BYTE_W-1:0];

   // write pairing: one byte mode always lands the low lane at position 0
   assign ins_hi = hi_first ? w_upper : w_lower;
   assign ins_lo = byte_mode ? w_lower : (hi_first ? w_lower : w_upper);

   // read pairing: missing bytes read as zero
   assign r0 = (fill != '0)           ? head0 : '0;
   assign r1 = (fill >= FILL_W'(2))   ? head1 : '0;
   assign rd_word = hi_first ? {r0, r1} : {r1, r0};
endmodule

// File: rtl/dbb_flags.sv
`timescale 1ns/1ps
module dbb_flags
   import dbb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_acc,
   input  logic              rd_acc,
   input  logic              empty,
   input  logic              mst_in,
   input  logic              rx_mode,
   output logic [STAT_W-1:0] stat_set,
   output logic [STAT_W-1:0] stat_clr,
   output logic              mst_clr,
   output logic              run_req
);
   logic rx_master;
   assign rx_master = mst_in && rx_mode;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_set <= '0;
         stat_clr <= '0;
         mst_clr  <= 1'b0;
         run_req  <= 1'b0;
      end else begin
         stat_set <= '0;
         stat_clr <= '0;
         if (wr_acc) begin
            stat_clr[ST_TXUDF] <= 1'b1;
            stat_clr[ST_TXRDY] <= 1'b1;
         end
         if (rd_acc) begin
            stat_clr[ST_RXRDY] <= 1'b1;
            stat_clr[ST_RXOVR] <= 1'b1;
            if (empty)     stat_set[ST_RDEMPTY] <= 1'b1;
            if (rx_master) stat_set[ST_ARDY]    <= 1'b1;
         end
         mst_clr <= rd_acc && rx_master;
         run_req <= wr_acc || rd_acc;
      end
   end

   a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |=> (stat_clr[ST_TXUDF] && stat_clr[ST_TXRDY]));
   a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |=> (stat_clr[ST_RXRDY] && stat_clr[ST_RXOVR]));
   a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && empty) |=> stat_set[ST_RDEMPTY]);
   a_r11_master_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && mst_in && rx_mode) |=> (stat_set[ST_ARDY] && mst_clr));
   a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_acc |=> (!mst_clr && !stat_set[ST_ARDY]));
   a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_acc || rd_acc) |=> !run_req);
endmodule

// File: rtl/dport_bytebuf.sv
`timescale 1ns/1ps
module dport_bytebuf
   import dbb_pkg::*;
#(
   parameter  int BUF_BYTES = 4,
   parameter  int PORT_W    = 16,
   localparam int FILL_W    = $clog2(BUF_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_first,
   input  logic              mst_in,
   input  logic              rx_mode,
   input  logic              wr_en,
   input  logic              wr_byte,
   input  logic [PORT_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [PORT_W-1:0] rd_data,
   input  logic              seq_push,
   input  logic [7:0]        seq_push_byte,
   input  logic              seq_pop,
   output logic [7:0]        seq_tx_byte,
   output logic [FILL_W-1:0] fill,
   output logic [15:0]       stat_set,
   output logic [15:0]       stat_clr,
   output logic              mst_clr,
   output logic              run_req
);
   if (BUF_BYTES < 2) begin : g_bad_depth
      $error("BUF_BYTES must hold at least one 16-bit word");
   end
   if (PORT_W != 2 * BYTE_W) begin : g_bad_port
      $error("PORT_W must be exactly two bytes");
   end

   logic              rd_acc;
   buf_op_e           op;
   byte_t             ins_hi, ins_lo, head0, head1;
   logic [PORT_W-1:0] rd_word;

   assign rd_acc = rd_en && !wr_en;

   always_comb begin
      if (wr_en)         op = wr_byte ? OP_WR1 : OP_WR2;
      else if (rd_en)    op = OP_RD;
      else if (seq_push) op = OP_PUSH;
      else if (seq_pop)  op = OP_POP;
      else               op = OP_NONE;
   end

   dbb_lane #(.PORT_W(PORT_W), .FILL_W(FILL_W)) u_lane (
      .hi_first  (hi_first),
      .byte_mode (wr_byte),
      .wr_word   (wr_data),
      .head0     (head0),
      .head1     (head1),
      .fill      (fill),
      .ins_hi    (ins_hi),
      .ins_lo    (ins_lo),
      .rd_word   (rd_word)
   );

   dbb_store #(.DEPTH(BUF_BYTES)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .ins_lo    (ins_lo),
      .ins_hi    (ins_hi),
      .push_byte (seq_push_byte),
      .head0     (head0),
      .head1     (head1),
      .tail      (seq_tx_byte),
      .fill      (fill)
   );

   dbb_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_acc   (wr_en),
      .rd_acc   (rd_acc),
      .empty    (fill == '0),
      .mst_in   (mst_in),
      .rx_mode  (rx_mode),
      .stat_set (stat_set),
      .stat_clr (stat_clr),
      .mst_clr  (mst_clr),
      .run_req  (run_req)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      rd_data <= '0;
      else if (rd_acc) rd_data <= rd_word;
   end

   a_r7_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_acc |=> $stable(rd_data));
   a_r14_read_yields: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en) |=> !stat_clr[ST_RXRDY]);
   a_r14_push_yields: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_byte && seq_push && fill == '0) |=> fill == FILL_W'(2));
endmodule

// File: tb/dport_bytebuf_test.sv
`timescale 1ns/1ps
module dport_bytebuf_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hi_first = 1'b1, mst_in = 1'b0, rx_mode = 1'b0;
   logic        wr_en = 1'b0, wr_byte = 1'b0, rd_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        seq_push = 1'b0, seq_pop = 1'b0;
   logic [7:0]  seq_push_byte = '0;
   logic [7:0]  seq_tx_byte;
   logic [2:0]  fill;
   logic [15:0] stat_set, stat_clr;
   logic        mst_clr, run_req;

   always #5 clk = ~clk;

   dport_bytebuf uut (.*);

   int total = 0, bad = 0;
   logic [15:0] rd_q [$];
   string       rd_t [$];
   logic [7:0]  tx_q [$];
   string       tx_t [$];
   logic        rd_pend = 1'b0;
   logic        exp_pop = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: compares design results against scoreboard queues
   always begin
      @(negedge clk);
      #2;
      if (rd_pend) begin
         rd_pend = 1'b0;
         if (rd_q.size() == 0) chk(1'b0, "R7 scoreboard empty", 0, 1);
         else begin
            logic [15:0] e;
            string t;
            e = rd_q.pop_front();
            t = rd_t.pop_front();
            chk(rd_data == e, t, rd_data, e);
         end
      end
      if (rd_en && !wr_en) rd_pend = 1'b1;
      if (seq_pop && exp_pop) begin
         if (tx_q.size() == 0) chk(1'b0, "R5 scoreboard empty", 0, 1);
         else begin
            logic [7:0] e;
            string t;
            e = tx_q.pop_front();
            t = tx_t.pop_front();
            chk(seq_tx_byte == e, t, seq_tx_byte, e);
         end
      end
   end

   task automatic wr16(input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_byte = 1'b0; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      chk(stat_clr[10] && stat_clr[4], "R9 write clears txudf/txrdy", stat_clr, 16'h0410);
      chk(run_req == 1'b1, "R12 run_req after write", run_req, 1);
   endtask

   task automatic wr8(input logic [7:0] b);
      @(negedge clk);
      wr_en = 1'b1; wr_byte = 1'b1; wr_data = {8'hEE, b};
      @(negedge clk);
      wr_en = 1'b0; wr_byte = 1'b0;
      chk(stat_clr[10] && stat_clr[4], "R9 byte write clears", stat_clr, 16'h0410);
   endtask

   task automatic rd(input logic [15:0] e, input string tag);
      rd_q.push_back(e); rd_t.push_back(tag);
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk(stat_clr[3] && stat_clr[11], "R10 read clears rxrdy/rxovr", stat_clr, 16'h0808);
      chk(run_req == 1'b1, "R12 run_req after read", run_req, 1);
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      seq_push = 1'b1; seq_push_byte = b;
      @(negedge clk);
      seq_push = 1'b0;
   endtask

   task automatic pop(input logic [7:0] e, input string tag);
      tx_q.push_back(e); tx_t.push_back(tag);
      @(negedge clk);
      seq_pop = 1'b1; exp_pop = 1'b1;
      @(negedge clk);
      seq_pop = 1'b0; exp_pop = 1'b0;
   endtask

   initial begin
      #1_000_000;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(fill == 0, "R1 fill after reset", fill, 0);
      chk(rd_data == 0, "R1 rd_data after reset", rd_data, 0);
      chk(stat_set == 0 && stat_clr == 0 && !mst_clr && !run_req, "R1 pulses idle", stat_set | stat_clr, 0);

      // R2 + R5: order bit set, drain highest first
      hi_first = 1'b1;
      wr16(16'hA1B2);
      chk(fill == 2, "R2 fill after word write", fill, 2);
      @(negedge clk);
      chk(run_req == 1'b0, "R12 run_req one cycle only", run_req, 0);
      pop(8'hA1, "R2 first tx byte hi_first=1");
      pop(8'hB2, "R5 second tx byte");
      chk(fill == 0, "R5 fill after drain", fill, 0);
      @(negedge clk); seq_pop = 1'b1; @(negedge clk); seq_pop = 1'b0;
      chk(fill == 0, "R5 pop on empty ignored", fill, 0);
      chk(seq_tx_byte == 0, "R5 tx byte zero when empty", seq_tx_byte, 0);

      // R3 reversed write pairing
      hi_first = 1'b0;
      wr16(16'hA1B2);
      pop(8'hB2, "R3 first tx byte hi_first=0");
      pop(8'hA1, "R3 second tx byte hi_first=0");

      // R4 odd final byte
      hi_first = 1'b1;
      wr16(16'h1122);
      wr8(8'h33);
      chk(fill == 3, "R4 fill after byte write", fill, 3);
      pop(8'h11, "R4 oldest byte first");
      pop(8'h22, "R4 middle byte");
      pop(8'h33, "R4 byte write at position 0");

      // R13 no room
      wr16(16'h4455);
      wr16(16'h6677);
      chk(fill == 4, "R13 full after two words", fill, 4);
      wr16(16'hDEAD);
      chk(fill == 4, "R13 word write refused when full", fill, 4);
      wr8(8'hBE);
      chk(fill == 4, "R13 byte write refused when full", fill, 4);
      pop(8'h44, "R13 contents kept 0");
      pop(8'h55, "R13 contents kept 1");
      pop(8'h66, "R13 contents kept 2");
      pop(8'h77, "R13 contents kept 3");

      // R7 reads, hi_first=1
      push(8'h10); push(8'h20); push(8'h30);
      chk(fill == 3, "R6 fill after pushes", fill, 3);
      rd(16'h1020, "R7 two-byte read hi_first=1");
      chk(fill == 1, "R7 fill after two-byte read", fill, 1);
      rd(16'h3000, "R7 lone byte hi_first=1");
      chk(fill == 0, "R7 fill after lone read", fill, 0);

      // R3 read pairing reversed
      hi_first = 1'b0;
      push(8'h44); push(8'h55); push(8'h66);
      rd(16'h5544, "R3 two-byte read hi_first=0");
      rd(16'h0066, "R3 lone byte hi_first=0");

      // R8 empty read
      rd(16'h0000, "R8 empty read returns zero");
      chk(stat_set[15] == 1'b1, "R8 empty read sets bit 15", stat_set, 16'h8000);
      chk(stat_set[2] == 1'b0 && !mst_clr, "R11 no ardy when not master", stat_set, 0);

      // R6 push when full
      hi_first = 1'b1;
      push(8'hC1); push(8'hC2); push(8'hC3); push(8'hC4);
      push(8'hC5);
      chk(fill == 4, "R6 push refused when full", fill, 4);
      rd(16'hC1C2, "R6 first pair kept");
      rd(16'hC3C4, "R6 second pair kept");

      // R11 master receive read
      mst_in = 1'b1; rx_mode = 1'b1;
      rd(16'h0000, "R11 read as master receiver");
      chk(stat_set[2] == 1'b1 && mst_clr == 1'b1, "R11 ardy and mst_clr", {mst_clr, stat_set}, 17'h18004);
      rx_mode = 1'b0;
      rd(16'h0000, "R11 read as master transmitter");
      chk(stat_set[2] == 1'b0 && mst_clr == 1'b0, "R11 no ardy when transmitting", stat_set, 16'h8000);
      mst_in = 1'b0;

      // R14 priority
      @(negedge clk);
      wr_en = 1'b1; wr_data = 16'hC0DE; rd_en = 1'b1; seq_push = 1'b1; seq_push_byte = 8'h99;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; seq_push = 1'b0;
      chk(fill == 2, "R14 push and read ignored during write", fill, 2);
      chk(stat_clr[3] == 1'b0, "R14 no read clear pulse", stat_clr, 16'h0410);
      chk(rd_data == 16'h0000, "R14 rd_data unchanged", rd_data, 0);
      @(negedge clk);
      wr_en = 1'b1; wr_byte = 1'b1; wr_data = 16'h0042; seq_pop = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_byte = 1'b0; seq_pop = 1'b0;
      chk(fill == 3, "R14 pop ignored during write", fill, 3);
      pop(8'hC0, "R14 word byte kept");
      pop(8'hDE, "R14 word low byte");
      pop(8'h42, "R14 byte write kept");

      repeat (3) @(negedge clk);
      chk(rd_q.size() == 0 && tx_q.size() == 0, "R7 scoreboard drained", rd_q.size() + tx_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule